// File: doc/BRIEF.md
# PCI Configuration Mechanism 1 Bridge

This block sits between a host I/O request bus and a configuration request port. Software selects a configuration target by writing a full dword to the address port at I/O 0CF8h. That dword is kept in a latch and holds an enable bit and the bus, device, function and dword-register fields. A later access to the data window at I/O 0CFCh becomes one configuration read or write to the selected register. The host byte enables choose which bytes take part.

Any host access that is not a configuration access is handed unchanged to an ordinary I/O pass-through port. This covers partial accesses to the address port, data-window accesses while the enable bit is clear, and every other address. The host sees one request at a time and waits for a one-cycle `h_ready` pulse, which comes only after the downstream side has answered.

Top module: `cfgm1_bridge`

## Requirements
- R1: After reset, `h_ready`, `c_req` and `p_req` are low, and a full-dword read of 0CF8h returns 00000000h.
- R2: A write to 0CF8h with all four byte enables set loads the latch with the write data masked by 80FFFFFCh. A full-dword read of 0CF8h returns the latch. Both complete with `h_ready` one cycle after the request is taken.
- R3: An access to 0CF8h with any byte enable clear goes to the pass-through port with the same address, byte enables, direction and data. It leaves the latch unchanged.
- R4: With latch bit 31 set, a data-window access with a nonzero byte-enable mask raises `c_req`. The fields come from the latch: bus from bits 23:16, device from bits 15:11, function from bits 10:8 and register from bits 7:2. Direction, byte enables and write data come from the host. Addresses 0CFCh to 0CFFh all count as the data window.
- R5: With latch bit 31 clear, a data-window access goes to the pass-through port and no configuration request is made.
- R6: With latch bit 31 set, a data-window access whose byte enables are all zero makes no configuration request. It completes one cycle later, and a read returns zero.
- R7: A claimed configuration read (`c_hit` high with `c_ack`) returns `c_rdata` on the byte lanes enabled in `h_be`. The other lanes read as zero.
- R8: An unclaimed configuration read returns FFh on every enabled lane and zero elsewhere. An unclaimed write completes normally.
- R9: `c_req` stays high with stable fields until `c_ack`, and `h_ready` stays low until then. Only one transaction is in flight. A configuration access completes two cycles after it is taken when `c_ack` arrives one cycle after `c_req`.
- R10: Accesses to any other address go to the pass-through port. A read returns `p_rdata`, and the access completes the cycle after `p_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_req | input | 1 | Host request, held until `h_ready` |
| h_wr | input | 1 | Host write (1) or read (0) |
| h_addr | input | IO_AW | Host I/O byte address |
| h_be | input | 4 | Host byte enables |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, valid with `h_ready` |
| h_ready | output | 1 | One-cycle completion pulse |
| c_req | output | 1 | Configuration request, held until `c_ack` |
| c_wr | output | 1 | Configuration write |
| c_bus | output | 8 | Target bus |
| c_dev | output | 5 | Target device |
| c_fn | output | 3 | Target function |
| c_reg | output | 6 | Target dword register index |
| c_be | output | 4 | Configuration byte enables |
| c_wdata | output | 32 | Configuration write data |
| c_ack | input | 1 | Configuration response strobe |
| c_hit | input | 1 | Response claimed by a device |
| c_rdata | input | 32 | Configuration read data |
| p_req | output | 1 | Pass-through request, held until `p_ack` |
| p_wr | output | 1 | Pass-through write |
| p_addr | output | IO_AW | Pass-through address |
| p_be | output | 4 | Pass-through byte enables |
| p_wdata | output | 32 | Pass-through write data |
| p_ack | input | 1 | Pass-through response strobe |
| p_rdata | input | 32 | Pass-through read data |

## Verification
Timing depends on the kind of access, counted from the falling edge where the request is raised:
- Latch accesses and empty-mask data-window accesses finish after one cycle.
- Configuration and pass-through accesses finish after two cycles, because the bench responders acknowledge one cycle after they see the request.

The bench counts falling edges until `h_ready` and compares that count with the expected value for every vector. The read data, the captured downstream fields and the responder counters are sampled on that same edge.

// File: rtl/cfgm1_pkg.sv
package cfgm1_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_CFG, ST_IO, ST_DONE} cfgm1_state_e;
   typedef enum logic [2:0] {K_LWR, K_LRD, K_CFG, K_NOP, K_FWD} cfgm1_kind_e;
   localparam logic [31:0] LATCH_KEEP = 32'h80FF_FFFC;
   localparam int LANES = 4;
endpackage

// File: rtl/cfgm1_decode.sv
module cfgm1_decode #(
   parameter int IO_AW = 16,
   parameter logic [IO_AW-1:0] ADDR_PORT = 'h0CF8,
   parameter logic [IO_AW-1:0] DATA_PORT = 'h0CFC
) (
   input  logic [IO_AW-3:0] dw_addr,
   input  logic             wr,
   input  logic [3:0]       be,
   input  logic             latch_en,
   output cfgm1_pkg::cfgm1_kind_e kind
);
   import cfgm1_pkg::*;
   localparam logic [IO_AW-3:0] ADDR_DW = ADDR_PORT[IO_AW-1:2];
   localparam logic [IO_AW-3:0] DATA_DW = DATA_PORT[IO_AW-1:2];

   logic at_addr, at_data, full;
   assign at_addr = (dw_addr == ADDR_DW);
   assign at_data = (dw_addr == DATA_DW);
   assign full    = &be;

   always_comb begin
      if (at_addr && full)
         kind = wr ? K_LWR : K_LRD;
      else if (at_data && latch_en)
         kind = (be == 4'h0) ? K_NOP : K_CFG;
      else
         kind = K_FWD;
   end
endmodule

// File: rtl/cfgm1_addr_latch.sv
module cfgm1_addr_latch (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        load,
   input  logic [31:0] wdata,
   output logic [31:0] q
);
   import cfgm1_pkg::*;
   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= 32'h0;
      else if (load)
         q <= wdata & LATCH_KEEP;
   end

   // R2
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> ((q[30:24] == 7'h0) && (q[1:0] == 2'h0)));
endmodule

// File: rtl/cfgm1_ctrl.sv
module cfgm1_ctrl #(
   parameter int IO_AW = 16,
   parameter bit FILL_ONES = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   h_req,
   input  logic                   h_wr,
   input  logic [IO_AW-1:0]       h_addr,
   input  logic [3:0]             h_be,
   input  logic [31:0]            h_wdata,
   input  cfgm1_pkg::cfgm1_kind_e kind,
   input  logic [31:0]            latch_q,
   output logic                   latch_load,
   output logic                   idle,
   output logic [31:0]            h_rdata,
   output logic                   h_ready,
   output logic                   c_req,
   output logic                   c_wr,
   output logic [3:0]             c_be,
   output logic [31:0]            c_wdata,
   input  logic                   c_ack,
   input  logic                   c_hit,
   input  logic [31:0]            c_rdata,
   output logic                   p_req,
   output logic                   p_wr,
   output logic [IO_AW-1:0]       p_addr,
   output logic [3:0]             p_be,
   output logic [31:0]            p_wdata,
   input  logic                   p_ack,
   input  logic [31:0]            p_rdata
);
   import cfgm1_pkg::*;

   cfgm1_state_e      state_q;
   logic              rq_wr;
   logic [IO_AW-1:0]  rq_addr;
   logic [3:0]        rq_be;
   logic [31:0]       rq_wdata;
   logic [31:0]       rdata_q;
   logic [31:0]       fill_word;
   logic [31:0]       cfg_word;

   generate
      if (FILL_ONES) begin : g_fill_ones
         assign fill_word = 32'hFFFF_FFFF;
      end else begin : g_fill_zero
         assign fill_word = 32'h0;
      end
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         assign cfg_word[8*k +: 8] = rq_be[k] ?
            (c_hit ? c_rdata[8*k +: 8] : fill_word[8*k +: 8]) : 8'h00;
      end
   endgenerate

   assign idle       = (state_q == ST_IDLE);
   assign latch_load = idle && h_req && (kind == K_LWR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         rq_wr    <= 1'b0;
         rq_addr  <= '0;
         rq_be    <= 4'h0;
         rq_wdata <= 32'h0;
         rdata_q  <= 32'h0;
      end else begin
         case (state_q)
            ST_IDLE: if (h_req) begin
               rq_wr    <= h_wr;
               rq_addr  <= h_addr;
               rq_be    <= h_be;
               rq_wdata <= h_wdata;
               case (kind)
                  K_LWR, K_NOP: begin rdata_q <= 32'h0;   state_q <= ST_DONE; end
                  K_LRD:        begin rdata_q <= latch_q; state_q <= ST_DONE; end
                  K_CFG:        state_q <= ST_CFG;
                  default:      state_q <= ST_IO;
               endcase
            end
            ST_CFG: if (c_ack) begin
               rdata_q <= rq_wr ? 32'h0 : cfg_word;
               state_q <= ST_DONE;
            end
            ST_IO: if (p_ack) begin
               rdata_q <= rq_wr ? 32'h0 : p_rdata;
               state_q <= ST_DONE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign h_ready = (state_q == ST_DONE);
   assign h_rdata = h_ready ? rdata_q : 32'h0;
   assign c_req   = (state_q == ST_CFG);
   assign c_wr    = rq_wr;
   assign c_be    = rq_be;
   assign c_wdata = rq_wdata;
   assign p_req   = (state_q == ST_IO);
   assign p_wr    = rq_wr;
   assign p_addr  = rq_addr;
   assign p_be    = rq_be;
   assign p_wdata = rq_wdata;

   // R9
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (c_req && !c_ack) |=> (c_req && $stable(c_be) && $stable(c_wdata)));
   // R9
   ready_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(c_req) |-> !h_ready);
   // R6
   no_empty_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
      c_req |-> (c_be != 4'h0));
   // R9
   single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({c_req, p_req, h_ready}));
endmodule

// File: rtl/cfgm1_bridge.sv
module cfgm1_bridge #(
   parameter int IO_AW = 16,
   parameter logic [IO_AW-1:0] ADDR_PORT = 'h0CF8,
   parameter logic [IO_AW-1:0] DATA_PORT = 'h0CFC,
   parameter bit FILL_ONES = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              h_req,
   input  logic              h_wr,
   input  logic [IO_AW-1:0]  h_addr,
   input  logic [3:0]        h_be,
   input  logic [31:0]       h_wdata,
   output logic [31:0]       h_rdata,
   output logic              h_ready,
   output logic              c_req,
   output logic              c_wr,
   output logic [7:0]        c_bus,
   output logic [4:0]        c_dev,
   output logic [2:0]        c_fn,
   output logic [5:0]        c_reg,
   output logic [3:0]        c_be,
   output logic [31:0]       c_wdata,
   input  logic              c_ack,
   input  logic              c_hit,
   input  logic [31:0]       c_rdata,
   output logic              p_req,
   output logic              p_wr,
   output logic [IO_AW-1:0]  p_addr,
   output logic [3:0]        p_be,
   output logic [31:0]       p_wdata,
   input  logic              p_ack,
   input  logic [31:0]       p_rdata
);
   import cfgm1_pkg::*;

   generate
      if (IO_AW < 12) begin : g_bad_aw
         $error("IO_AW must reach the configuration ports");
      end
      if (ADDR_PORT[1:0] != 2'b00 || DATA_PORT[1:0] != 2'b00) begin : g_bad_align
         $error("ports must be dword aligned");
      end
      if (ADDR_PORT[IO_AW-1:2] == DATA_PORT[IO_AW-1:2]) begin : g_bad_overlap
         $error("address and data ports must differ");
      end
   endgenerate

   cfgm1_kind_e kind;
   logic [31:0] latch_q;
   logic        latch_load;
   logic        idle;

   cfgm1_decode #(.IO_AW(IO_AW), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)) u_dec (
      .dw_addr(h_addr[IO_AW-1:2]), .wr(h_wr), .be(h_be),
      .latch_en(latch_q[31]), .kind(kind));

   cfgm1_addr_latch u_latch (
      .clk(clk), .rst_n(rst_n), .load(latch_load), .wdata(h_wdata), .q(latch_q));

   cfgm1_ctrl #(.IO_AW(IO_AW), .FILL_ONES(FILL_ONES)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_wr(h_wr), .h_addr(h_addr),
      .h_be(h_be), .h_wdata(h_wdata), .kind(kind), .latch_q(latch_q),
      .latch_load(latch_load), .idle(idle), .h_rdata(h_rdata), .h_ready(h_ready),
      .c_req(c_req), .c_wr(c_wr), .c_be(c_be), .c_wdata(c_wdata),
      .c_ack(c_ack), .c_hit(c_hit), .c_rdata(c_rdata),
      .p_req(p_req), .p_wr(p_wr), .p_addr(p_addr), .p_be(p_be), .p_wdata(p_wdata),
      .p_ack(p_ack), .p_rdata(p_rdata));

   assign c_bus = latch_q[23:16];
   assign c_dev = latch_q[15:11];
   assign c_fn  = latch_q[10:8];
   assign c_reg = latch_q[7:2];

   // R3
   fwd_keeps_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && h_req && kind == K_FWD) |=> $stable(latch_q));
   // R5
   cfg_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      c_req |-> latch_q[31]);
   // R4
   cfg_fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (c_req && !c_ack) |=> ($stable(c_bus) && $stable(c_dev) && $stable(c_fn) && $stable(c_reg)));
endmodule

// File: tb/sim_cfgm1_bridge.sv
module sim_cfgm1_bridge;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic        h_req = 0, h_wr = 0;
   logic [15:0] h_addr = 0;
   logic [3:0]  h_be = 0;
   logic [31:0] h_wdata = 0;
   logic [31:0] h_rdata;
   logic        h_ready;
   logic        c_req, c_wr;
   logic [7:0]  c_bus;
   logic [4:0]  c_dev;
   logic [2:0]  c_fn;
   logic [5:0]  c_reg;
   logic [3:0]  c_be;
   logic [31:0] c_wdata;
   logic        c_ack = 0, c_hit = 0;
   logic [31:0] c_rdata = 0;
   logic        p_req, p_wr;
   logic [15:0] p_addr;
   logic [3:0]  p_be;
   logic [31:0] p_wdata;
   logic        p_ack = 0;
   logic [31:0] p_rdata = 0;

   int vecs = 0, bad = 0;
   int dev_n = 0, io_n = 0;
   logic [23:0] cap_sel;
   logic [3:0]  cap_be, pcap_be;
   logic        cap_wr, pcap_wr;
   logic [31:0] cap_wd, pcap_wd;
   logic [15:0] pcap_addr;

   cfgm1_bridge u0 (.*);

   // configuration responder: devices 0..3 claim, acknowledge one cycle after request
   always @(negedge clk) begin
      if (c_req && !c_ack) begin
         c_ack   <= 1'b1;
         c_hit   <= (c_dev < 5'd4);
         c_rdata <= {8'hC3, c_bus, c_dev, c_fn, c_reg, 2'b00};
         cap_sel <= {c_bus, c_dev, c_fn, c_reg, 2'b00};
         cap_be  <= c_be; cap_wr <= c_wr; cap_wd <= c_wdata;
         dev_n   <= dev_n + 1;
      end else begin
         c_ack <= 1'b0;
      end
   end

   // pass-through responder
   always @(negedge clk) begin
      if (p_req && !p_ack) begin
         p_ack     <= 1'b1;
         p_rdata   <= {16'h5EED, p_addr ^ 16'h0F0F};
         pcap_addr <= p_addr; pcap_be <= p_be; pcap_wr <= p_wr; pcap_wd <= p_wdata;
         io_n      <= io_n + 1;
      end else begin
         p_ack <= 1'b0;
      end
   end

   function automatic logic [31:0] lanes(input logic [3:0] be);
      return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      vecs++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic do_io(input logic wr, input logic [15:0] a, input logic [3:0] be,
                        input logic [31:0] wd, output logic [31:0] rd, output int cyc);
      @(negedge clk);
      h_req = 1; h_wr = wr; h_addr = a; h_be = be; h_wdata = wd;
      cyc = 0;
      do begin @(negedge clk); cyc++; end while (!h_ready && cyc < 40);
      if (!h_ready) begin
         vecs++; bad++;
         $display("FAIL handshake timeout got=0 exp=1");
      end
      rd = h_rdata;
      h_req = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      vecs++; bad++;
      $display("FAIL watchdog got=expired exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end

   initial begin
      logic [31:0] rd, v, lat;
      int cyc, n0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1
      chk("R1 h_ready", 32'(h_ready), 0);
      chk("R1 c_req", 32'(c_req), 0);
      chk("R1 p_req", 32'(p_req), 0);
      do_io(0, 16'h0CF8, 4'hF, 0, rd, cyc);
      chk("R1 latch", rd, 0);

      // R2: latch sweep
      for (int i = 0; i < 32; i++) begin
         v = (32'(i) * 32'h9E37_79B9) ^ (32'(i) << 31);
         do_io(1, 16'h0CF8, 4'hF, v, rd, cyc);
         chk("R2 write cycles", 32'(cyc), 1);
         do_io(0, 16'h0CF8, 4'hF, 0, rd, cyc);
         chk("R2 readback", rd, v & 32'h80FF_FFFC);
         chk("R2 read cycles", 32'(cyc), 1);
      end

      // R3: partial accesses to the address port
      lat = 32'h8012_3456 & 32'h80FF_FFFC;
      do_io(1, 16'h0CF8, 4'hF, lat, rd, cyc);
      for (int be = 0; be < 15; be++) begin
         for (int w = 0; w < 2; w++) begin
            n0 = io_n;
            v  = 32'hA000_0000 | 32'(be * 16 + w);
            do_io(w[0], 16'h0CF8, be[3:0], v, rd, cyc);
            chk("R3 fwd count", 32'(io_n), 32'(n0 + 1));
            chk("R3 fwd addr", 32'(pcap_addr), 32'h0CF8);
            chk("R3 fwd be", 32'(pcap_be), 32'(be));
            chk("R3 fwd wr", 32'(pcap_wr), 32'(w));
            if (w == 1) chk("R3 fwd wdata", pcap_wd, v);
            else chk("R3 fwd rdata", rd, {16'h5EED, 16'h0CF8 ^ 16'h0F0F});
            do_io(0, 16'h0CF8, 4'hF, 0, rd, cyc);
            chk("R3 latch kept", rd, lat);
         end
      end

      // R4 R6 R7 R8 R9: configuration sweep
      for (int d = 0; d < 8; d++) begin
         for (int be = 0; be < 16; be++) begin
            for (int w = 0; w < 2; w++) begin
               logic [7:0] bus; logic [2:0] fn; logic [5:0] rg; logic [23:0] sel;
               bus = 8'h10 + 8'(d);
               fn  = 3'(d) ^ 3'h5;
               rg  = 6'(d * 7 + be);
               sel = {bus, 5'(d), fn, rg, 2'b00};
               do_io(1, 16'h0CF8, 4'hF, {8'h80, sel}, rd, cyc);
               n0 = dev_n;
               v  = 32'h1357_9BDF ^ 32'(d * 256 + be);
               do_io(w[0], 16'h0CFC + 16'(be % 4), be[3:0], v, rd, cyc);
               if (be == 0) begin
                  chk("R6 no request", 32'(dev_n), 32'(n0));
                  chk("R6 cycles", 32'(cyc), 1);
                  chk("R6 rdata", rd, 0);
               end else begin
                  chk("R4 request count", 32'(dev_n), 32'(n0 + 1));
                  chk("R4 fields", 32'(cap_sel), 32'(sel));
                  chk("R4 be", 32'(cap_be), 32'(be));
                  chk("R4 wr", 32'(cap_wr), 32'(w));
                  chk("R9 cycles", 32'(cyc), 2);
                  if (w == 1) begin
                     chk("R4 wdata", cap_wd, v);
                     chk("R8 write rdata", rd, 0);
                  end else if (d < 4) begin
                     chk("R7 claimed read", rd, {8'hC3, sel} & lanes(be[3:0]));
                  end else begin
                     chk("R8 unclaimed read", rd, lanes(be[3:0]));
                  end
               end
            end
         end
      end

      // R5: enable clear forwards the data window
      do_io(1, 16'h0CF8, 4'hF, 32'h0001_0800, rd, cyc);
      for (int be = 0; be < 16; be++) begin
         n0 = dev_n;
         do_io(0, 16'h0CFC, be[3:0], 0, rd, cyc);
         chk("R5 no cfg", 32'(dev_n), 32'(n0));
         chk("R5 fwd addr", 32'(pcap_addr), 32'h0CFC);
         chk("R5 fwd rdata", rd, {16'h5EED, 16'h0CFC ^ 16'h0F0F});
      end

      // R10: other addresses
      for (int i = 0; i < 16; i++) begin
         logic [15:0] a;
         a  = 16'(i * 16'h0131 + 16'h0080);
         n0 = io_n;
         do_io(i[0], a, 4'hF, 32'(i), rd, cyc);
         chk("R10 fwd count", 32'(io_n), 32'(n0 + 1));
         chk("R10 fwd addr", 32'(pcap_addr), 32'(a));
         chk("R10 cycles", 32'(cyc), 2);
         chk("R10 rdata", rd, i[0] ? 32'h0 : {16'h5EED, a ^ 16'h0F0F});
      end

      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end
endmodule